// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

The block drives a three-wire digital audio link as clock master. It divides the system clock down to a bit clock. It generates the frame (left/right) clock. It shifts stereo PCM words out on a serial data line. Each frame is 64 bit-clock slots long. Samples go out most significant bit first. Any slot that carries no sample bit is driven low. The framing is chosen at run time from four formats: right-justified, left-justified, I2S and DSP. The same control lines select the word length, the bit-clock polarity and one shared bit. In the three justified/I2S formats that shared bit inverts the frame clock. In DSP format it chooses early or late timing.

Samples arrive as parallel left/right pairs through a valid/ready handshake into a one-pair holding buffer. At every frame boundary the block latches the control lines and moves the buffered pair into the shifter. A control change therefore never disturbs a frame that is already in progress. If no pair is waiting at the boundary, the frame is sent as zeros and the underflow output pulses. A right-justified frame with a 32-bit word request is illegal. The block raises a configuration error flag for that frame and sends 24-bit words in its place.

Top module: `pcm_ser_tx`

## Requirements
- R1: Reset sets ready_o to 1. It sets bclk_o, lrclk_o, sdata_o, underflow_o and cfg_err_o to 0. Reset loads the configuration I2S, 24-bit, both polarity bits 0. The first frame after reset carries zero data and gives no underflow pulse.
- R2: One bit-clock period lasts 2*HALF_DIV system clocks. With bclk_inv_i=0 the bit clock is low in the first half of each slot and high in the second half. Data and frame clock change only at slot starts, which are the falling edges of the normal bit clock. With bclk_inv_i=1, bclk_o is the complement.
- R3: fmt_i=01 is left-justified. The frame clock is high for the left channel, over the first 32 slots of the frame. The MSB goes out in the first slot after each frame-clock edge, followed by the top N bits of the 32-bit input word. Setting fsync_alt_i=1 inverts the frame clock.
- R4: fmt_i=10 is I2S. The frame clock is low for the left channel. Each of its edges comes one slot before the MSB of the next channel. Setting fsync_alt_i=1 inverts the frame clock.
- R5: fmt_i=00 is right-justified. Each word ends so that its LSB sits in the last slot before the next frame-clock edge. The frame clock is high for left. Setting fsync_alt_i=1 inverts it.
- R6: fmt_i=11 is DSP. The frame clock is high for one slot per frame. The left word and the right word follow each other with no gap. With fsync_alt_i=0 (early), the left MSB shares the pulse slot. With fsync_alt_i=1 (late), the left MSB starts one slot after the pulse.
- R7: wlen_i codes 00, 01, 10 and 11 give 16, 20, 24 and 32 bits. All control inputs take effect only at the next frame boundary. Right-justified with 32 bits is replaced by 24 bits, and cfg_err_o is high for that frame.
- R8: A pair is accepted when valid_i and ready_o are both high. ready_o then drops until the pair is moved into the shifter at the next frame boundary.
- R9: If no pair is buffered at a frame boundary, underflow_o is high for exactly one system clock at the start of the new frame, and that frame sends only zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing format code |
| fsync_alt_i | input | 1 | Frame-clock inversion, or DSP late timing |
| bclk_inv_i | input | 1 | Bit-clock inversion |
| wlen_i | input | 2 | Word length code |
| left_i | input | 32 | Left sample, MSB-aligned |
| right_i | input | 32 | Right sample, MSB-aligned |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Holding buffer empty |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | One-clock pulse when a frame starts without data |
| cfg_err_o | output | 1 | Illegal format/length combination latched for this frame |

## Verification
Every pin result is decoded from registers that advance on the same system-clock edge. A slot's data and frame-clock values therefore appear in the first clock after that slot starts, and they hold for all 2*HALF_DIV clocks of the slot. The bench counts clocks from reset release. It checks each slot's data and frame clock one clock after the slot starts, and it checks the bit clock in both halves. Control inputs are changed at mid-frame. The bench's model applies them from the next frame, and underflow and error flags are checked in the first clock of each frame. A pair that is offered is scored for the frame after the one in which it is accepted. A pair offered in the last clock of a frame is never driven, so there is no edge race.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int SLOT_W   = 6;   // 64 slots per frame

  typedef enum logic [1:0] {FMT_RJ = 2'b00, FMT_LJ = 2'b01, FMT_I2S = 2'b10, FMT_DSP = 2'b11} fmt_e;
  typedef enum logic [1:0] {WL_16 = 2'b00, WL_20 = 2'b01, WL_24 = 2'b10, WL_32 = 2'b11} wl_e;

  typedef struct packed {
    fmt_e fmt;
    logic alt;
    logic binv;
    wl_e  wl;
  } cfg_t;

  localparam cfg_t CFG_RST = '{fmt: FMT_I2S, alt: 1'b0, binv: 1'b0, wl: WL_24};

  function automatic int wl_len(wl_e w);
    case (w)
      WL_16:   return 16;
      WL_20:   return 20;
      WL_24:   return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/sertx_timebase.sv
`timescale 1ns/1ps
module sertx_timebase #(
  parameter int HALF_DIV = 2,
  parameter int SLOT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_start_o,
  output logic              phase_hi_o,
  output logic              frame_end_o
);
  localparam int CW = $clog2(2*HALF_DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(2*HALF_DIV-1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF_DIV);

  logic [CW-1:0]     cnt_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      slot_q <= slot_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign slot_o       = slot_q;
  assign slot_start_o = (cnt_q == '0);
  assign phase_hi_o   = (cnt_q >= CNT_HALF);
  assign frame_end_o  = (cnt_q == CNT_LAST) && (&slot_q);
endmodule

// File: rtl/sertx_cfg.sv
`timescale 1ns/1ps
module sertx_cfg
  import sertx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] fmt_i,
  input  logic       alt_i,
  input  logic       binv_i,
  input  logic [1:0] wl_i,
  output cfg_t       cfg_o,
  output logic       err_o
);
  logic illegal;
  assign illegal = (fmt_e'(fmt_i) == FMT_RJ) && (wl_e'(wl_i) == WL_32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
      err_o <= 1'b0;
    end else if (load_i) begin
      cfg_o.fmt  <= fmt_e'(fmt_i);
      cfg_o.alt  <= alt_i;
      cfg_o.binv <= binv_i;
      cfg_o.wl   <= illegal ? WL_24 : wl_e'(wl_i);
      err_o      <= illegal;
    end
  end
endmodule

// File: rtl/sertx_buf.sv
`timescale 1ns/1ps
module sertx_buf #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                load_i,
  output logic                ready_o,
  output logic [SAMPLE_W-1:0] tx_l_o,
  output logic [SAMPLE_W-1:0] tx_r_o,
  output logic                underflow_o
);
  logic                have_q;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
  logic                accept;

  assign ready_o = !have_q;
  assign accept  = valid_i && !have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q      <= 1'b0;
      hold_l_q    <= '0;
      hold_r_q    <= '0;
      tx_l_o      <= '0;
      tx_r_o      <= '0;
      underflow_o <= 1'b0;
    end else begin
      underflow_o <= load_i && !have_q;
      if (load_i) begin
        tx_l_o <= have_q ? hold_l_q : '0;
        tx_r_o <= have_q ? hold_r_q : '0;
      end
      if (accept) begin
        hold_l_q <= left_i;
        hold_r_q <= right_i;
        have_q   <= 1'b1;
      end else if (load_i) begin
        have_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sertx_map.sv
`timescale 1ns/1ps
module sertx_map
  import sertx_pkg::*;
#(
  parameter int SLOT_W   = 6,
  parameter int SAMPLE_W = 32
) (
  input  logic [SLOT_W-1:0]   slot_i,
  input  fmt_e                fmt_i,
  input  logic                alt_i,
  input  wl_e                 wl_i,
  input  logic [SAMPLE_W-1:0] tx_l_i,
  input  logic [SAMPLE_W-1:0] tx_r_i,
  output logic                sdata_o,
  output logic                lrclk_o
);
  localparam int PW   = SLOT_W + 1;
  localparam int IW   = $clog2(SAMPLE_W);
  localparam int HALF = 2**(SLOT_W-1);
  localparam logic [PW-1:0] P_HALF = PW'(HALF);
  localparam logic [PW-1:0] P_FULL = PW'(2*HALF);

  logic [PW-1:0]       s_ext, n_len;
  logic [PW-1:0]       st [2];
  logic [SAMPLE_W-1:0] word [2];
  logic [1:0]          hit, bitv;

  assign s_ext   = {1'b0, slot_i};
  assign n_len   = PW'(wl_len(wl_i));
  assign word[0] = tx_l_i;
  assign word[1] = tx_r_i;

  always_comb begin
    st[0] = (fmt_i == FMT_RJ) ? P_HALF - n_len : '0;
    case (fmt_i)
      FMT_RJ:  st[1] = P_FULL - n_len;
      FMT_DSP: st[1] = n_len;
      default: st[1] = P_HALF;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [PW-1:0] off;
    assign off     = s_ext - st[c];
    assign hit[c]  = (s_ext >= st[c]) && (s_ext < st[c] + n_len);
    assign bitv[c] = word[c][IW'(SAMPLE_W-1) - off[IW-1:0]];
  end

  assign sdata_o = |(hit & bitv);

  always_comb begin
    case (fmt_i)
      FMT_I2S: lrclk_o = ((s_ext >= P_HALF - 1'b1) && (s_ext < P_FULL - 1'b1)) ^ alt_i;
      FMT_DSP: lrclk_o = alt_i ? (&slot_i) : (slot_i == '0);
      default: lrclk_o = (s_ext < P_HALF) ^ alt_i;
    endcase
  end
endmodule

// File: rtl/pcm_ser_tx.sv
`timescale 1ns/1ps
module pcm_ser_tx
  import sertx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic                fsync_alt_i,
  input  logic                bclk_inv_i,
  input  logic [1:0]          wlen_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o,
  output logic                underflow_o,
  output logic                cfg_err_o
);
  logic [SLOT_W-1:0]   slot_q;
  logic                slot_start, phase_hi, frame_end;
  cfg_t                cfg_q;
  logic [SAMPLE_W-1:0] tx_l, tx_r;

  sertx_timebase #(.HALF_DIV(HALF_DIV), .SLOT_W(SLOT_W)) i_timebase (
    .clk_i, .rst_ni,
    .slot_o(slot_q), .slot_start_o(slot_start),
    .phase_hi_o(phase_hi), .frame_end_o(frame_end)
  );

  sertx_cfg i_cfg (
    .clk_i, .rst_ni, .load_i(frame_end),
    .fmt_i, .alt_i(fsync_alt_i), .binv_i(bclk_inv_i), .wl_i(wlen_i),
    .cfg_o(cfg_q), .err_o(cfg_err_o)
  );

  sertx_buf #(.SAMPLE_W(SAMPLE_W)) i_buf (
    .clk_i, .rst_ni, .valid_i, .left_i, .right_i, .load_i(frame_end),
    .ready_o, .tx_l_o(tx_l), .tx_r_o(tx_r), .underflow_o
  );

  sertx_map #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) i_map (
    .slot_i(slot_q), .fmt_i(cfg_q.fmt), .alt_i(cfg_q.alt), .wl_i(cfg_q.wl),
    .tx_l_i(tx_l), .tx_r_i(tx_r), .sdata_o, .lrclk_o
  );

  assign bclk_o = phase_hi ^ cfg_q.binv;
endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk
  import sertx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input cfg_t              cfg_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic              slot_start_i,
  input logic              lrclk_i,
  input logic              sdata_i,
  input logic              underflow_i,
  input logic              valid_i,
  input logic              ready_i
);
  AST_RJ_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.fmt == FMT_RJ) |-> (cfg_i.wl != WL_32)); // R7

  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_i |-> ($stable(sdata_i) && $stable(lrclk_i))); // R2

  AST_UFLOW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |=> !underflow_i); // R9

  AST_UFLOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |-> !sdata_i); // R9

  AST_ACCEPT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i) |=> !ready_i); // R8

  AST_DSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.fmt == FMT_DSP && slot_i != '0 && !(&slot_i)) |-> !lrclk_i); // R6
endmodule

bind pcm_ser_tx sertx_chk i_sertx_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_q), .slot_i(slot_q),
  .slot_start_i(slot_start), .lrclk_i(lrclk_o), .sdata_i(sdata_o),
  .underflow_i(underflow_o), .valid_i(valid_i), .ready_i(ready_o)
);

// File: tb/test_pcm_ser_tx.sv
`timescale 1ns/1ps
module test_pcm_ser_tx;
  localparam int SLOT_CLK  = 4;             // HALF_DIV = 2
  localparam int FRAME_CLK = 64 * SLOT_CLK;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  fmt_i = 2'b10, wlen_i = 2'b10;
  logic        fsync_alt_i = 1'b0, bclk_inv_i = 1'b0, valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic        ready_o, bclk_o, lrclk_o, sdata_o, underflow_o, cfg_err_o;

  int checks = 0, fails = 0, cyc = 0, pair_no = 0;
  bit done = 1'b0;
  logic [63:0] pend[$];

  // model of the frame in flight
  logic [1:0]  m_fmt = 2'b10, m_wl = 2'b10;
  logic        m_alt = 1'b0, m_binv = 1'b0, m_err = 1'b0, m_uf = 1'b0;
  logic [31:0] m_l = '0, m_r = '0;

  pcm_ser_tx #(.HALF_DIV(2)) i_pcm_ser_tx (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'b00:   return "R5";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic logic exp_sd(input int s, input logic [1:0] f, input logic [1:0] w,
                                  input logic [31:0] a, input logic [31:0] b);
    int n = (w == 2'b11) ? 32 : 16 + 4 * int'(w);
    int p = s % 32;
    logic [31:0] wd = (s < 32) ? a : b;
    case (f)
      2'b00: if (p >= 32 - n) return wd[31 - (p - (32 - n))];
      2'b11: begin
        if (s < n) return a[31 - s];
        if (s < 2 * n) return b[31 - (s - n)];
      end
      default: if (p < n) return wd[31 - p];
    endcase
    return 1'b0;
  endfunction

  function automatic logic exp_lr(input int s, input logic [1:0] f, input logic alt);
    case (f)
      2'b10:   return ((s >= 31) && (s < 63)) ^ alt;
      2'b11:   return alt ? (s == 63) : (s == 0);
      default: return (s < 32) ^ alt;
    endcase
  endfunction

  // monitor: scores every slot against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int ph = cyc % SLOT_CLK;
      int s  = (cyc / SLOT_CLK) % 64;
      if (cyc % FRAME_CLK == 0) begin
        chk("R9", "underflow", underflow_o, m_uf);
        chk("R7", "cfg_err", cfg_err_o, m_err);
      end
      if (ph == 1 || ph == 3)
        chk("R2", "bclk", bclk_o, (ph == 3) ^ m_binv);
      if (ph == 1) begin
        chk(m_uf ? "R9" : req_of(m_fmt), "sdata", sdata_o, exp_sd(s, m_fmt, m_wl, m_l, m_r));
        chk(req_of(m_fmt), "lrclk", lrclk_o, exp_lr(s, m_fmt, m_alt));
      end
      if (cyc % FRAME_CLK == FRAME_CLK - 1) begin
        m_fmt  = fmt_i;
        m_alt  = fsync_alt_i;
        m_binv = bclk_inv_i;
        m_err  = (fmt_i == 2'b00) && (wlen_i == 2'b11);
        m_wl   = m_err ? 2'b10 : wlen_i;
        if (pend.size() > 0) begin
          {m_l, m_r} = pend.pop_front();
          m_uf = 1'b0;
        end else begin
          m_l = '0; m_r = '0; m_uf = 1'b1;
        end
      end
    end
  end

  // driver: offers pairs and pushes them into the scoreboard queue
  task automatic send_pairs(input int k);
    for (int j = 0; j < k; j++) begin
      forever begin
        @(negedge clk_i);
        if (ready_o && (cyc % FRAME_CLK) != FRAME_CLK - 1) break;
      end
      pair_no++;
      left_i  = 32'h8123_4567 + pair_no * 32'h1357_9BDF;
      right_i = ~left_i ^ {pair_no[7:0], 24'h5A_C3F0};
      valid_i = 1'b1;
      pend.push_back({left_i, right_i});
      @(negedge clk_i);
      valid_i = 1'b0;
      chk("R8", "ready after accept", ready_o, 1'b0);
    end
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic alt, input logic binv, input logic [1:0] w);
    forever begin
      @(negedge clk_i);
      if (cyc % FRAME_CLK == FRAME_CLK / 2) break;
    end
    fmt_i = f; fsync_alt_i = alt; bclk_inv_i = binv; wlen_i = w;
  endtask

  initial begin
    #12;
    chk("R1", "ready", ready_o, 1'b1);
    chk("R1", "bclk", bclk_o, 1'b0);
    chk("R1", "lrclk", lrclk_o, 1'b0);
    chk("R1", "sdata", sdata_o, 1'b0);
    chk("R1", "underflow", underflow_o, 1'b0);
    chk("R1", "cfg_err", cfg_err_o, 1'b0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    send_pairs(3);                        // I2S 24-bit default
    set_cfg(2'b01, 1'b1, 1'b0, 2'b00);    // LJ 16, inverted frame clock
    send_pairs(3);
    set_cfg(2'b00, 1'b0, 1'b0, 2'b01);    // RJ 20
    send_pairs(2);
    set_cfg(2'b00, 1'b1, 1'b0, 2'b11);    // RJ 32: illegal, falls back
    send_pairs(2);
    set_cfg(2'b11, 1'b0, 1'b0, 2'b11);    // DSP early 32
    send_pairs(2);
    set_cfg(2'b11, 1'b1, 1'b1, 2'b00);    // DSP late 16, inverted bit clock
    send_pairs(2);
    set_cfg(2'b10, 1'b1, 1'b1, 2'b11);    // I2S 32, both inverted
    send_pairs(2);
    repeat (3 * FRAME_CLK) @(negedge clk_i);   // starved frames
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule